// File: doc/BRIEF.md
# Legacy Memory Window Routing Decoder

This block sits in a host bridge. It holds the attribute registers for the legacy memory windows below 1 MiB, the control register for the system-management RAM window, and a read-only byte that reports the installed memory size. The block decodes every CPU memory request in the first megabyte and chooses its target: DRAM or the PCI bus. One select output is driven for each target.

Software programs the registers through a dword configuration port with byte enables. Writes are committed on the clock edge, and read data is returned in the same cycle. The route for a CPU request is combinational. It depends on the request and on the register contents, so a register write made at one edge governs the CPU request presented in the next cycle.

There are thirteen attribute windows. Window 0 is the 64 KiB firmware area at the top of the first megabyte. Windows 1 to 12 are 16 KiB expansion areas, placed one after another from 0xC0000. Each window has a read-enable bit and a write-enable bit. The 128 KiB management window at 0xA0000 follows different rules. Its route depends on an open bit, a global enable bit and the CPU's management-mode flag.

Top module: `lmw_route_top`

## Requirements
- R1: After reset, the attribute bytes at config offsets 0x59–0x5F read 0x00. The management control byte at 0x72 reads 0x02. The size byte at 0x57 reads the parameter RAM_MB divided by 8, saturated at 255 (64 for the default of 512).
- R2: A config read returns four bytes for the dword addressed by cfg_addr[7:2]. Byte offset o appears in cfg_rdata bits [8*(o%4)+7 : 8*(o%4)]. Any byte that is not implemented reads 0x00.
- R3: A config write changes only the bytes whose cfg_be bit is set. Bytes in the other lanes of the same dword keep their values.
- R4: Window 0 uses the high nibble of byte 0x59. For a window w from 1 to 12, the attributes are in byte 0x59+ceil(w/2): the low nibble when w is odd, the high nibble when w is even. Within a nibble, bit 0 enables reads and bit 1 enables writes. Nibble bits 3:2 and the low nibble of 0x59 always read as zero, and writes to them are ignored.
- R5: Window 0 covers 0xF0000–0xFFFFF. Window w from 1 to 12 covers 0xC0000+(w-1)*0x4000 through that address plus 0x3FFF. The management window covers 0xA0000–0xBFFFF.
- R6: A read that falls in an attribute window goes to DRAM when that window's read-enable bit is set, and to PCI when it is clear. A write follows the window's write-enable bit in the same way.
- R7: Bits 2:0 of the management control byte are read-only and hold 010. Bits 7:3 are writable. Bit 6 is the open bit and bit 3 is the global enable. The byte changes only when it is written.
- R8: A request to the management window goes to DRAM in two cases: it is made in management mode while the global enable bit is set, or the open bit is set. In every other case it goes to PCI.
- R9: Any request below 0xA0000 goes to DRAM.
- R10: While cpu_valid is high, exactly one of sel_dram and sel_pci is high. While cpu_valid is low, both are low. The selects follow the request in the same cycle.
- R11: A config write made at a clock edge decides the route of the CPU request presented in the following cycle. A request presented in the same cycle as the write still uses the old value.
- R12: The size byte at 0x57 is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config byte address; bits 7:2 select the dword |
| cfg_be | input | 4 | Byte enables for the write lanes |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for the addressed dword |
| cpu_valid | input | 1 | CPU memory request present |
| cpu_addr | input | 20 | CPU physical address within the first megabyte |
| cpu_write | input | 1 | Request is a write (1) or a read (0) |
| cpu_smm | input | 1 | CPU is in system-management mode |
| sel_dram | output | 1 | Route the request to DRAM |
| sel_pci | output | 1 | Route the request to the PCI bus |

## Verification
A wrong internal bit in this block shows up in two places: the read-back data of its config byte, and the route chosen for a CPU request in the matching window. Both appear in the same cycle as the first request that exposes the bit. The bench keeps a byte-level model of the config space and a behavioural route function, and checks the read data and the selects on every cycle. Any corrupted nibble, misplaced window boundary or wrong management-window rule is therefore caught the first time a request or a read touches it. Directed steps cover the moment a write takes effect, byte-enable masking, the read-only bits and the window edges before random traffic begins.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

   // Attribute nibble: bit 1 enables writes, bit 0 enables reads
   typedef struct packed {
      logic wr_en;
      logic rd_en;
   } attr_t;

   localparam int unsigned SMR_OPEN_BIT = 6;
   localparam int unsigned SMR_GEN_BIT  = 3;
   localparam logic [2:0]  SMR_FIXED    = 3'b010;

   // Byte (relative to the first attribute byte) that holds window w
   function automatic int unsigned attr_byte_of(input int unsigned w);
      return (w + 1) / 2;
   endfunction

   // Even windows (including window 0) use the high nibble
   function automatic bit attr_in_high(input int unsigned w);
      return (w % 2) == 0;
   endfunction

endpackage

// File: rtl/lmw_cfg_regs.sv
module lmw_cfg_regs
   import lmw_pkg::*;
#(
   parameter int unsigned CFG_AW     = 8,
   parameter int unsigned ATTR_BASE  = 'h59,
   parameter int unsigned ATTR_BYTES = 7,
   parameter int unsigned NWIN       = 13,
   parameter int unsigned SMR_OFS    = 'h72,
   parameter int unsigned RSZ_OFS    = 'h57,
   parameter int unsigned RAM_MB     = 512
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [CFG_AW-1:0]      cfg_addr,
   input  logic [3:0]             cfg_be,
   input  logic [31:0]            cfg_wdata,
   output logic [31:0]            cfg_rdata,
   output attr_t [NWIN-1:0]       attr_o,
   output logic [7:0]             smram_o
);

   localparam int unsigned RSZ_UNITS = RAM_MB / 8;
   localparam logic [7:0]  RSZ_VAL   = (RSZ_UNITS > 255) ? 8'd255 : 8'(RSZ_UNITS);
   localparam logic [CFG_AW-1:0] RSZ_OFS_V = CFG_AW'(RSZ_OFS);
   localparam logic [CFG_AW-1:0] SMR_OFS_V = CFG_AW'(SMR_OFS);
   localparam int unsigned SMR_LANE = SMR_OFS % 4;

   if (NWIN != 2 * ATTR_BYTES - 1) begin : g_bad_nwin
      $error("lmw_cfg_regs: NWIN must equal 2*ATTR_BYTES-1");
   end
   if (CFG_AW < 3) begin : g_bad_aw
      $error("lmw_cfg_regs: CFG_AW too small");
   end

   attr_t [NWIN-1:0] attr_q;
   logic  [4:0]      smr_q;
   logic             unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   // one attribute field per window, placed by the package helpers
   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam int unsigned OFS  = ATTR_BASE + attr_byte_of(w);
      localparam int unsigned LANE = OFS % 4;
      localparam int unsigned SH   = attr_in_high(w) ? 4 : 0;
      localparam logic [CFG_AW-1:0] OFS_V = CFG_AW'(OFS);
      logic hit;

      assign hit = cfg_we && (cfg_addr[CFG_AW-1:2] == OFS_V[CFG_AW-1:2]) && cfg_be[LANE];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   attr_q[w] <= '0;
         else if (hit) attr_q[w] <= attr_t'(cfg_wdata[8*LANE+SH +: 2]);
      end
      assign attr_o[w] = attr_q[w];
   end

   logic smr_hit;
   assign smr_hit = cfg_we && (cfg_addr[CFG_AW-1:2] == SMR_OFS_V[CFG_AW-1:2]) && cfg_be[SMR_LANE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       smr_q <= 5'b00000;
      else if (smr_hit) smr_q <= cfg_wdata[8*SMR_LANE+3 +: 5];
   end

   assign smram_o = {smr_q, SMR_FIXED};

   logic [3:0][7:0] rd_lane;

   always_comb begin
      for (int b = 0; b < 4; b++) begin
         rd_lane[b] = 8'h00;
         if ({cfg_addr[CFG_AW-1:2], 2'(b)} == RSZ_OFS_V) rd_lane[b] = RSZ_VAL;
         if ({cfg_addr[CFG_AW-1:2], 2'(b)} == SMR_OFS_V) rd_lane[b] = {smr_q, SMR_FIXED};
         for (int w = 0; w < NWIN; w++) begin
            if ({cfg_addr[CFG_AW-1:2], 2'(b)} == CFG_AW'(ATTR_BASE + attr_byte_of(w))) begin
               rd_lane[b] = rd_lane[b] |
                  (attr_in_high(w) ? {2'b00, attr_q[w], 4'h0} : {6'h00, attr_q[w]});
            end
         end
      end
   end

   assign cfg_rdata = rd_lane;

endmodule

// File: rtl/lmw_route_dec.sv
module lmw_route_dec
   import lmw_pkg::*;
#(
   parameter int unsigned AW        = 20,
   parameter int unsigned NWIN      = 13,
   parameter int unsigned BIOS_BASE = 'hF0000,
   parameter int unsigned BIOS_SIZE = 'h10000,
   parameter int unsigned EXP_BASE  = 'hC0000,
   parameter int unsigned EXP_SIZE  = 'h4000,
   parameter int unsigned SMR_BASE  = 'hA0000,
   parameter int unsigned SMR_SIZE  = 'h20000
) (
   input  logic              req_valid,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_write,
   input  logic              req_smm,
   input  attr_t [NWIN-1:0]  attr,
   input  logic              smr_open,
   input  logic              smr_gen,
   output logic              to_dram,
   output logic              to_pci
);

   localparam int unsigned EXP_END = EXP_BASE + (NWIN - 1) * EXP_SIZE;

   if (AW > 31) begin : g_bad_aw
      $error("lmw_route_dec: AW must be below 32");
   end
   if (EXP_END > BIOS_BASE) begin : g_bad_map
      $error("lmw_route_dec: expansion windows overlap the firmware window");
   end
   if (SMR_BASE + SMR_SIZE > EXP_BASE) begin : g_bad_smr
      $error("lmw_route_dec: management window overlaps expansion windows");
   end

   logic [31:0]     addr_ext;
   logic [NWIN-1:0] win_hit;
   logic [NWIN-1:0] rd_ok;
   logic [NWIN-1:0] wr_ok;

   assign addr_ext = {{(32-AW){1'b0}}, req_addr};

   for (genvar w = 0; w < NWIN; w++) begin : g_cmp
      localparam int unsigned LO = (w == 0) ? BIOS_BASE : EXP_BASE + (w - 1) * EXP_SIZE;
      localparam int unsigned HI = LO + ((w == 0) ? BIOS_SIZE : EXP_SIZE);
      assign win_hit[w] = (addr_ext >= LO) && (addr_ext < HI);
      assign rd_ok[w]   = attr[w].rd_en;
      assign wr_ok[w]   = attr[w].wr_en;
   end

   logic in_attr;
   logic in_smr;
   logic route_dram;

   assign in_attr = |win_hit;
   assign in_smr  = (addr_ext >= SMR_BASE) && (addr_ext < SMR_BASE + SMR_SIZE);

   always_comb begin
      if (in_attr)     route_dram = req_write ? |(win_hit & wr_ok) : |(win_hit & rd_ok);
      else if (in_smr) route_dram = (req_smm && smr_gen) || smr_open;
      else             route_dram = 1'b1;
   end

   assign to_dram = req_valid &&  route_dram;
   assign to_pci  = req_valid && !route_dram;

endmodule

// File: rtl/lmw_route_top.sv
module lmw_route_top
   import lmw_pkg::*;
#(
   parameter int unsigned AW         = 20,
   parameter int unsigned CFG_AW     = 8,
   parameter int unsigned ATTR_BASE  = 'h59,
   parameter int unsigned ATTR_BYTES = 7,
   parameter int unsigned SMR_OFS    = 'h72,
   parameter int unsigned RSZ_OFS    = 'h57,
   parameter int unsigned RAM_MB     = 512,
   parameter int unsigned BIOS_BASE  = 'hF0000,
   parameter int unsigned BIOS_SIZE  = 'h10000,
   parameter int unsigned EXP_BASE   = 'hC0000,
   parameter int unsigned EXP_SIZE   = 'h4000,
   parameter int unsigned SMR_BASE   = 'hA0000,
   parameter int unsigned SMR_SIZE   = 'h20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              cpu_valid,
   input  logic [AW-1:0]     cpu_addr,
   input  logic              cpu_write,
   input  logic              cpu_smm,
   output logic              sel_dram,
   output logic              sel_pci
);

   localparam int unsigned NWIN = 2 * ATTR_BYTES - 1;

   attr_t [NWIN-1:0] attr_vec;
   logic  [7:0]      smram_byte;
   logic             unused_smr;

   assign unused_smr = ^{smram_byte[7], smram_byte[5:4], smram_byte[2:0]};

   lmw_cfg_regs #(
      .CFG_AW(CFG_AW), .ATTR_BASE(ATTR_BASE), .ATTR_BYTES(ATTR_BYTES), .NWIN(NWIN),
      .SMR_OFS(SMR_OFS), .RSZ_OFS(RSZ_OFS), .RAM_MB(RAM_MB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_o(attr_vec), .smram_o(smram_byte)
   );

   lmw_route_dec #(
      .AW(AW), .NWIN(NWIN), .BIOS_BASE(BIOS_BASE), .BIOS_SIZE(BIOS_SIZE),
      .EXP_BASE(EXP_BASE), .EXP_SIZE(EXP_SIZE), .SMR_BASE(SMR_BASE), .SMR_SIZE(SMR_SIZE)
   ) u_dec (
      .req_valid(cpu_valid), .req_addr(cpu_addr), .req_write(cpu_write), .req_smm(cpu_smm),
      .attr(attr_vec), .smr_open(smram_byte[SMR_OPEN_BIT]), .smr_gen(smram_byte[SMR_GEN_BIT]),
      .to_dram(sel_dram), .to_pci(sel_pci)
   );

endmodule

// File: rtl/lmw_route_chk.sv
module lmw_route_chk #(
   parameter int unsigned AW       = 20,
   parameter int unsigned SMR_BASE = 'hA0000,
   parameter int unsigned SMR_SIZE = 'h20000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic          cpu_valid,
   input logic [AW-1:0] cpu_addr,
   input logic          cpu_smm,
   input logic [7:0]    smram_byte,
   input logic          sel_dram,
   input logic          sel_pci
);

   logic [31:0] a32;
   logic        in_smr;
   assign a32    = {{(32-AW){1'b0}}, cpu_addr};
   assign in_smr = (a32 >= SMR_BASE) && (a32 < SMR_BASE + SMR_SIZE);

   // R10
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> $countones({sel_dram, sel_pci}) == 1);

   // R10
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid |-> !sel_dram && !sel_pci);

   // R9
   low_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && a32 < SMR_BASE) |-> sel_dram);

   // R8
   smm_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && in_smr && cpu_smm && smram_byte[3]) |-> sel_dram);

   // R8
   smr_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && in_smr && !cpu_smm && !smram_byte[6]) |-> sel_pci);

   // R7
   smr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> $stable(smram_byte));

endmodule

bind lmw_route_top lmw_route_chk #(
   .AW(AW), .SMR_BASE(SMR_BASE), .SMR_SIZE(SMR_SIZE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
   .cpu_smm(cpu_smm), .smram_byte(smram_byte), .sel_dram(sel_dram), .sel_pci(sel_pci)
);

// File: tb/lmw_route_top_bench.sv
module lmw_route_top_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_addr;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic [31:0] cfg_rdata_sat;
   logic        cpu_valid;
   logic [19:0] cpu_addr;
   logic        cpu_write;
   logic        cpu_smm;
   logic        sel_dram, sel_pci;
   logic        sat_dram, sat_pci;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   bit [7:0] m [256];

   always #(CLK_P/2) clk = ~clk;

   lmw_route_top u_lmw_route_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
      .cpu_write(cpu_write), .cpu_smm(cpu_smm), .sel_dram(sel_dram), .sel_pci(sel_pci)
   );

   lmw_route_top #(.RAM_MB(4096)) u_lmw_route_top_sat (
      .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_sat), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
      .cpu_write(cpu_write), .cpu_smm(cpu_smm), .sel_dram(sat_dram), .sel_pci(sat_pci)
   );

   function automatic bit [7:0] wmask(input int o);
      if (o == 'h59) return 8'h30;
      if (o >= 'h5A && o <= 'h5F) return 8'h33;
      if (o == 'h72) return 8'hF8;
      return 8'h00;
   endfunction

   function automatic bit exp_dram(input int a, input bit wr, input bit smm);
      int w;
      bit [7:0] byt;
      bit [3:0] nib;
      if (a >= 'hC0000) begin
         w   = (a >= 'hF0000) ? 0 : 1 + (a - 'hC0000) / 'h4000;
         byt = m['h59 + (w + 1) / 2];
         nib = (w % 2 == 0) ? byt[7:4] : byt[3:0];
         return wr ? nib[1] : nib[0];
      end
      if (a >= 'hA0000) return (smm && m['h72][3]) || m['h72][6];
      return 1'b1;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m[i] = 8'h00;
      m['h57] = 8'd64;
      m['h72] = 8'h02;
   endtask

   // compare outputs mid-cycle, then commit the model at the edge
   task automatic run_cycle(input string tag);
      string    rt;
      int       base;
      bit       d;
      logic [31:0] exp_rd;
      #1;
      base   = {cfg_addr[7:2], 2'b00};
      exp_rd = {m[base+3], m[base+2], m[base+1], m[base]};
      chk((tag == "") ? "R2" : tag, cfg_rdata, exp_rd);
      if (tag != "")                 rt = tag;
      else if (!cpu_valid)           rt = "R10";
      else if (cpu_addr < 'hA0000)   rt = "R9";
      else if (cpu_addr < 'hC0000)   rt = "R8";
      else                           rt = "R6";
      d = exp_dram(int'(cpu_addr), cpu_write, cpu_smm);
      chk(rt, {30'd0, sel_dram, sel_pci}, cpu_valid ? {30'd0, d, !d} : 32'd0);
      @(posedge clk);
      if (cfg_we && rst_n) begin
         for (int b = 0; b < 4; b++) begin
            if (cfg_be[b]) begin
               bit [7:0] mk;
               mk = wmask(base + b);
               m[base+b] = (m[base+b] & ~mk) | (cfg_wdata[8*b +: 8] & mk);
            end
         end
      end
      @(negedge clk);
   endtask

   task automatic set_cfg(input bit we, input int a, input bit [3:0] be, input bit [31:0] d);
      cfg_we = we; cfg_addr = 8'(a); cfg_be = be; cfg_wdata = d;
   endtask

   task automatic set_cpu(input bit v, input int a, input bit wr, input bit smm);
      cpu_valid = v; cpu_addr = 20'(a); cpu_write = wr; cpu_smm = smm;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      set_cfg(0, 'h54, 4'h0, 0);
      set_cpu(0, 0, 0, 0);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, including the saturated size byte
      set_cfg(0, 'h54, 0, 0);
      #1 chk("R1", {24'd0, cfg_rdata_sat[31:24]}, 32'd255);
      run_cycle("R1");
      set_cfg(0, 'h58, 0, 0); run_cycle("R1");
      set_cfg(0, 'h5C, 0, 0); run_cycle("R1");
      set_cfg(0, 'h70, 0, 0); run_cycle("R1");

      // R12 size byte ignores writes
      set_cfg(1, 'h54, 4'hF, 32'hFFFF_FFFF); run_cycle("R12");
      set_cfg(0, 'h54, 0, 0); run_cycle("R12");

      // R3 only enabled lanes change
      set_cfg(1, 'h5C, 4'b0101, 32'h3333_3333); run_cycle("R3");
      set_cfg(0, 'h5C, 0, 0); run_cycle("R3");

      // R4 nibble layout and reserved bits
      set_cfg(1, 'h58, 4'hF, 32'hFFFF_FFFF); run_cycle("R4");
      set_cfg(0, 'h58, 0, 0); run_cycle("R4");
      set_cfg(1, 'h58, 4'hF, 32'h0000_0000); run_cycle("R4");

      // R11 same-cycle request sees old value, next cycle sees new
      set_cfg(1, 'h58, 4'b0100, 32'h0001_0000); set_cpu(1, 'hC0000, 0, 0); run_cycle("R11");
      set_cfg(0, 'h58, 0, 0); run_cycle("R11");
      set_cpu(1, 'hC4000, 0, 0); run_cycle("R4");
      set_cpu(1, 'hC0000, 1, 0); run_cycle("R6");

      // R7 read-only low bits of management byte
      set_cfg(1, 'h70, 4'b0100, 32'h00FF_0000); run_cycle("R7");
      set_cfg(0, 'h70, 0, 0); run_cycle("R7");
      set_cpu(1, 'hA0000, 0, 0); run_cycle("R8");
      set_cfg(1, 'h70, 4'b0100, 32'h0008_0000); run_cycle("R7");
      set_cfg(0, 'h70, 0, 0); set_cpu(1, 'hBFFFF, 0, 0); run_cycle("R8");
      set_cpu(1, 'hBFFFF, 1, 1); run_cycle("R8");

      // R5 window edges
      set_cfg(1, 'h5C, 4'hF, 32'h0130_0000);
      set_cpu(0, 0, 0, 0); run_cycle("R5");
      set_cfg(1, 'h58, 4'hF, 32'h0000_1110); run_cycle("R5");
      set_cfg(0, 'h58, 0, 0);
      set_cpu(1, 'hEFFFF, 0, 0); run_cycle("R5");
      set_cpu(1, 'hF0000, 0, 0); run_cycle("R5");
      set_cpu(1, 'hC7FFF, 0, 0); run_cycle("R5");
      set_cpu(1, 'hC8000, 0, 0); run_cycle("R5");
      set_cpu(1, 'h9FFFF, 0, 0); run_cycle("R9");
      set_cpu(1, 'hFFFFF, 0, 0); run_cycle("R5");

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         int r;
         int a;
         r = $urandom_range(0, 3);
         case (r)
            0: a = $urandom_range(0, 'h9FFFF);
            1: a = $urandom_range('hA0000, 'hBFFFF);
            2: a = $urandom_range('hC0000, 'hEFFFF);
            default: a = $urandom_range('hF0000, 'hFFFFF);
         endcase
         set_cpu($urandom_range(0, 7) != 0, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         case ($urandom_range(0, 3))
            0: r = 'h54;
            1: r = 'h58;
            2: r = 'h5C;
            default: r = 'h70;
         endcase
         set_cfg($urandom_range(0, 2) == 0, r, 4'($urandom_range(0, 15)), $urandom);
         run_cycle("");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule